// File: doc/BRIEF.md
# EEPROM Write Trigger and Byte-Load Timer

This block is the part of a parallel EEPROM that decides when internal programming begins. It watches an active-low write strobe that has already been sampled into the clock domain. A low pulse counts as a write only if it lasts long enough; shorter pulses are treated as noise. Each accepted strobe produces a one-clock byte-latch pulse, and the page latches (outside this block) use that pulse to capture address and data.

Every low-to-high transition of the strobe restarts a byte-load window. If the strobe goes low again before the window ends, the count stops, and the next byte joins the same page load. If the window runs out with the strobe still high, a programming cycle of fixed length starts. A one-clock start pulse marks its beginning, and a busy flag stays high for the whole cycle. Strobes are ignored while programming is under way. Strobes are also ignored during a write-lockout interval that follows reset.

Top module: `eeprom_prog_trigger`

## Requirements
- R1: While reset is held and in the first cycle after it, `byte_latch`, `prog_start` and `busy` are all 0.
- R2: A strobe whose rising sample falls within the first INHIBIT_CYC clock edges after reset release produces no byte latch and starts no programming.
- R3: A low pulse seen at fewer than MIN_LOW_CYC consecutive clock edges produces no byte latch.
- R4: A low pulse seen at MIN_LOW_CYC or more consecutive edges, followed by a high sample, raises `byte_latch` for exactly one cycle, starting right after the edge that sampled `wr_n` high.
- R5: With no further strobe activity, `prog_start` is high for exactly one cycle, WINDOW_CYC cycles after `byte_latch` was raised.
- R6: A low sample of `wr_n` at any edge up to and including the WINDOW_CYC-th edge after the last rising sample cancels the pending start. The next start is timed from the following rising sample.
- R7: `busy` rises together with `prog_start` and stays high for exactly PROGRAM_CYC cycles.
- R8: Strobes while `busy` is high produce no byte latch and start no load window, so no second programming cycle follows.
- R9: The rising sample that ends a rejected short pulse during a pending page load still restarts the load window, and starts it from that edge, without latching a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_n | input | 1 | Sampled write strobe, active low |
| byte_latch | output | 1 | One-cycle pulse: capture the current byte |
| prog_start | output | 1 | One-cycle pulse: internal programming begins |
| busy | output | 1 | High during the programming cycle |

## Verification
The bench sends a pulse one sample shorter than the minimum and one at exactly the minimum. A filter off by one would latch the short pulse or drop the valid one. It places the next strobe's falling sample on the very edge where the window would expire. A timer that compares against the wrong terminal value would then start programming early, in the middle of the page. It also ends a short pulse inside a pending page load. A timer that ignores that rising edge, or restarts it one count off, would start programming at the wrong cycle. Finally, it sends strobes during lockout and during busy; a design that fails to gate these would latch bytes or launch a second programming cycle.

// File: rtl/wrctl_pkg.sv
// Shared helpers for the EEPROM write trigger.
// Assumes: counter limits are positive integers.
package wrctl_pkg;
    // Bits needed to hold values 0..n inclusive.
    function automatic int cnt_w(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction
endpackage

// File: rtl/wr_strobe_filter.sv
// Edge detect and runt rejection for the sampled write strobe.
// Counts consecutive low samples (saturating at MIN_LOW_CYC); a rising
// sample is accepted only when that count reached the threshold and
// enable_i is high. Assumes wr_n is already synchronous to clk.
module wr_strobe_filter #(
    parameter int MIN_LOW_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_n,
    input  logic enable_i,
    output logic rise_o,
    output logic accept_o,
    output logic byte_latch_o
);
    import wrctl_pkg::*;
    localparam int LW = cnt_w(MIN_LOW_CYC);
    localparam logic [LW-1:0] LOW_MAX = LW'(MIN_LOW_CYC);

    logic          wr_prev;
    logic [LW-1:0] low_cnt;

    assign rise_o   = wr_n & ~wr_prev;
    assign accept_o = rise_o & (low_cnt == LOW_MAX) & enable_i;

    // Track previous sample and saturating low-run length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_prev <= 1'b1;
            low_cnt <= '0;
        end else begin
            wr_prev <= wr_n;
            if (wr_n)
                low_cnt <= '0;
            else if (low_cnt != LOW_MAX)
                low_cnt <= low_cnt + 1'b1;
        end
    end

    // Register the one-cycle byte-latch pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) byte_latch_o <= 1'b0;
        else        byte_latch_o <= accept_o;
    end

    AST_LATCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_latch_o |=> !byte_latch_o); // R4
    AST_LATCH_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        byte_latch_o |-> ($past(wr_n) && !$past(wr_n, 2))); // R3
endmodule

// File: rtl/wr_load_timer.sv
// Retriggerable byte-load window. Armed by an accepted strobe; the count
// is held at zero while the strobe is low and restarts on every rising
// sample. Expiry fires when WINDOW_CYC high edges pass after the last rise.
// Assumes WINDOW_CYC >= 2.
module wr_load_timer #(
    parameter int WINDOW_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_n,
    input  logic rise_i,
    input  logic accept_i,
    output logic expire_o
);
    import wrctl_pkg::*;
    localparam int TW = cnt_w(WINDOW_CYC);
    localparam logic [TW-1:0] LAST = TW'(WINDOW_CYC - 1);

    logic          pending;
    logic [TW-1:0] cnt;

    assign expire_o = pending & wr_n & ~rise_i & (cnt == LAST);

    // Arm, hold, restart and expire the load window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            cnt     <= '0;
        end else begin
            if (accept_i)      pending <= 1'b1;
            else if (expire_o) pending <= 1'b0;
            if (!wr_n || rise_i || expire_o)
                cnt <= '0;
            else if (pending)
                cnt <= cnt + 1'b1;
        end
    end

    AST_EXPIRE_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> !pending); // R5
    AST_LOW_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |=> (cnt == '0)); // R6
endmodule

// File: rtl/wr_prog_timer.sv
// Fixed-length programming cycle: a start request raises a one-cycle
// start pulse and holds busy for PROGRAM_CYC cycles.
// Assumes start_i is never raised while busy_o is high.
module wr_prog_timer #(
    parameter int PROGRAM_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic prog_start_o,
    output logic busy_o
);
    import wrctl_pkg::*;
    localparam int PW = cnt_w(PROGRAM_CYC);
    localparam logic [PW-1:0] LAST = PW'(PROGRAM_CYC - 1);

    logic [PW-1:0] pcnt;

    // Run the programming counter and busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o       <= 1'b0;
            prog_start_o <= 1'b0;
            pcnt         <= '0;
        end else begin
            prog_start_o <= start_i;
            if (start_i) begin
                busy_o <= 1'b1;
                pcnt   <= '0;
            end else if (busy_o) begin
                if (pcnt == LAST) busy_o <= 1'b0;
                else              pcnt   <= pcnt + 1'b1;
            end
        end
    end

    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start_o |-> busy_o); // R7
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start_o |=> !prog_start_o); // R5
    AST_NO_RESTART_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !start_i); // R8
endmodule

// File: rtl/wr_lockout.sv
// Power-up write lockout: holds inhibit_o high for the first
// INHIBIT_CYC clock edges after reset release.
module wr_lockout #(
    parameter int INHIBIT_CYC = 32
) (
    input  logic clk,
    input  logic rst_n,
    output logic inhibit_o
);
    import wrctl_pkg::*;
    localparam int IW = cnt_w(INHIBIT_CYC);
    localparam logic [IW-1:0] DONE = IW'(INHIBIT_CYC);

    logic [IW-1:0] icnt;

    assign inhibit_o = (icnt != DONE);

    // Count up to the lockout length and stop.
    always_ff @(posedge clk) begin
        if (!rst_n)          icnt <= '0;
        else if (inhibit_o)  icnt <= icnt + 1'b1;
    end
endmodule

// File: rtl/eeprom_prog_trigger.sv
// Top of the EEPROM write trigger: runt filter, byte-load window,
// programming timer and power-up lockout. Writes are accepted only when
// neither busy nor locked out. Assumes wr_n is synchronised to clk.
module eeprom_prog_trigger #(
    parameter int MIN_LOW_CYC = 2,
    parameter int WINDOW_CYC  = 5000,
    parameter int PROGRAM_CYC = 250000,
    parameter int INHIBIT_CYC = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_n,
    output logic byte_latch,
    output logic prog_start,
    output logic busy
);
    logic rise, accept, expire, inhibit, enable;

    assign enable = ~busy & ~inhibit;

    wr_strobe_filter #(.MIN_LOW_CYC(MIN_LOW_CYC)) u_filter (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .enable_i(enable),
        .rise_o(rise), .accept_o(accept), .byte_latch_o(byte_latch)
    );

    wr_load_timer #(.WINDOW_CYC(WINDOW_CYC)) u_load (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rise_i(rise),
        .accept_i(accept), .expire_o(expire)
    );

    wr_prog_timer #(.PROGRAM_CYC(PROGRAM_CYC)) u_prog (
        .clk(clk), .rst_n(rst_n), .start_i(expire),
        .prog_start_o(prog_start), .busy_o(busy)
    );

    wr_lockout #(.INHIBIT_CYC(INHIBIT_CYC)) u_lock (
        .clk(clk), .rst_n(rst_n), .inhibit_o(inhibit)
    );

    AST_NO_LATCH_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        byte_latch |-> !$past(inhibit)); // R2
    AST_NO_LATCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        byte_latch |-> !$past(busy)); // R8
endmodule

// File: tb/eeprom_prog_trigger_tb_top.sv
// Scoreboard bench: driver tasks queue expected pulses with their cycle,
// a negedge monitor pops and compares them against the outputs.
module eeprom_prog_trigger_tb_top;
    localparam int MINL = 3;
    localparam int WIN  = 20;
    localparam int PRG  = 50;
    localparam int INH  = 30;

    typedef struct { int kind; int cyc; string req; } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_n = 1'b1;
    logic byte_latch, prog_start, busy;
    int   cyc = 0;
    int   errors = 0;
    int   checks = 0;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    eeprom_prog_trigger #(.MIN_LOW_CYC(MINL), .WINDOW_CYC(WIN),
                          .PROGRAM_CYC(PRG), .INHIBIT_CYC(INH)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n),
        .byte_latch(byte_latch), .prog_start(prog_start), .busy(busy)
    );

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    // Monitor: compare each produced pulse with the head of the queue.
    task automatic take(input int kind);
        exp_t e;
        if (exp_q.size() == 0) begin
            check(1'b0, kind == 0 ? "R3/R8 unexpected latch" : "R5/R6 unexpected start", cyc, -1);
        end else begin
            e = exp_q.pop_front();
            check(e.kind == kind && e.cyc == cyc, e.req, cyc, e.cyc);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (byte_latch) take(0);
            if (prog_start) take(1);
        end
    end

    task automatic push(input int kind, input int c, input string req);
        exp_t e;
        e.kind = kind; e.cyc = c; e.req = req;
        exp_q.push_back(e);
    endtask

    // Driver: one low pulse of the given length; returns the cycle of the rise.
    task automatic strobe(input int lows, input bit exp_latch, input string req, output int c_rise);
        wr_n = 1'b0;
        repeat (lows) @(negedge clk);
        wr_n = 1'b1;
        c_rise = cyc + 1;
        if (exp_latch) push(0, c_rise, req);
        @(negedge clk);
    endtask

    task automatic wait_cyc(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic finish_run();
        foreach (exp_q[i])
            check(1'b0, {exp_q[i].req, " missing pulse"}, -1, exp_q[i].cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", cyc, -1);
        finish_run();
    end

    initial begin
        int c0, c1, cs, cr;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!byte_latch && !prog_start && !busy, "R1 during reset", {byte_latch, prog_start, busy}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!byte_latch && !prog_start && !busy, "R1 after release", {byte_latch, prog_start, busy}, 0);

        // R2: strobe inside lockout is ignored
        strobe(5, 1'b0, "R2", c0);
        check(c0 < INH, "R2 rise inside lockout", c0, INH);
        wait_cyc(INH + WIN + 5);
        check(!busy, "R2 no programming", busy, 0);

        // R3: short pulse rejected
        strobe(MINL - 1, 1'b0, "R3", c0);
        wait_cyc(c0 + WIN + 5);
        check(!busy, "R3 no programming", busy, 0);

        // R4/R5/R7: single byte at the minimum width
        strobe(MINL, 1'b1, "R4 latch", c0);
        push(1, c0 + WIN, "R5 start");
        wait_cyc(c0 + WIN);
        check(busy, "R7 busy at start", busy, 1);
        wait_cyc(c0 + WIN + PRG - 1);
        check(busy, "R7 busy last cycle", busy, 1);
        @(negedge clk);
        check(!busy, "R7 busy cleared", busy, 0);

        // R6/R8: page of three bytes, then strobe while busy
        strobe(4, 1'b1, "R6 page byte 0", c0);
        repeat (5) @(negedge clk);
        strobe(4, 1'b1, "R6 page byte 1", c0);
        repeat (5) @(negedge clk);
        strobe(4, 1'b1, "R6 page byte 2", c0);
        cs = c0 + WIN;
        push(1, cs, "R6 page start");
        wait_cyc(cs + 5);
        strobe(4, 1'b0, "R8", c1);
        wait_cyc(cs + PRG);
        check(!busy, "R8 busy length unchanged", busy, 0);
        wait_cyc(cs + PRG + WIN + 5);
        check(!busy, "R8 no second cycle", busy, 0);

        // R6: falling sample on the expiry edge cancels the start
        strobe(MINL, 1'b1, "R6 boundary byte 0", c0);
        wait_cyc(c0 + WIN - 1);
        strobe(MINL, 1'b1, "R6 boundary byte 1", c1);
        check(!busy, "R6 no start at boundary", busy, 0);
        push(1, c1 + WIN, "R6 boundary start");
        wait_cyc(c1 + WIN + PRG + 2);
        check(!busy, "R6 boundary cycle done", busy, 0);

        // R9: runt during pending load restarts the window without a latch
        strobe(MINL, 1'b1, "R9 byte", c0);
        repeat (5) @(negedge clk);
        strobe(MINL - 1, 1'b0, "R9", cr);
        push(1, cr + WIN, "R9 start from runt rise");
        wait_cyc(cr + WIN);
        check(busy, "R9 busy at restarted expiry", busy, 1);
        wait_cyc(cr + WIN + PRG + 2);
        check(!busy, "R9 cycle done", busy, 0);

        finish_run();
    end
endmodule